// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block turns the address phase of a multiplexed address/data bus into active-low chip selects for a block of peripherals. Software places the peripheral block anywhere in the address map by writing a base value, and chooses whether the block decodes I/O cycles or memory cycles. Above that base, each 256-byte slice has its own select. Slice index 4 has no pin. Slice indices 0 to 3 and 5 and 6 do. Anything at index 7 or beyond selects nothing.

A select is decoded in the cycle where the address-valid strobe is high. It is registered on that edge and stays valid until the next strobe. A bus hold forces every select inactive and the block ignores strobes while hold lasts. The two pins for slices 5 and 6 have a second use. When the pin-mode bit is cleared they stop acting as selects and instead output address bits 1 and 2, latched on the strobe. During hold these latched bits keep their last values and do not go high.

There are no streamed data paths, so every pin is a plain control pin with no back-pressure. Configuration is loaded through a single write-enable port and applies from the next clock edge.

Top module: `psel_decoder`

## Requirements
- R1: After reset, all four low select outputs and both shared pins are high, the pin-mode bit is 1 (select mode), the base is 0 and the block decodes memory space.
- R2: A strobe whose address bits [19:11] equal the base, whose space flag matches the configured space, and whose bits [10:8] are 0 to 3 drives exactly that one low select output low from the next clock edge.
- R3: In select mode, a matching strobe with bits [10:8] equal to 5 or 6 drives the slice-5 or slice-6 shared pin low, and no other output.
- R4: A matching strobe with bits [10:8] equal to 4 or 7 leaves every output high.
- R5: A strobe whose upper bits differ from the base, or whose space flag (1 = I/O, 0 = memory) differs from the configured space, leaves every output high.
- R6: Outputs change only on a strobe edge. Without a strobe, the select taken on the last strobe stays asserted, and a new strobe replaces it.
- R7: While hold is high, every select is high and strobes are ignored. After hold ends, no select is asserted until the next strobe.
- R8: With the pin-mode bit at 0, the slice-5 pin shows address bit 1 and the slice-6 pin shows address bit 2, both latched from the last strobe. This happens for any address, whether it matches or not.
- R9: With the pin-mode bit at 0, the two shared pins keep their latched values while hold is high, even if a strobe arrives.
- R10: A configuration write (base, space bit, pin-mode bit) takes effect for strobes from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_base | input | 9 | Base value compared with address bits [19:11] |
| cfg_io_space | input | 1 | 1: decode I/O cycles, 0: decode memory cycles |
| cfg_sel_mode | input | 1 | 1: shared pins are selects, 0: shared pins are latched address bits |
| bus_as | input | 1 | Address-valid strobe |
| bus_addr | input | 20 | Bus address during the address phase |
| bus_io | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| bus_hold | input | 1 | Bus hold active |
| psel_n | output | 4 | Active-low selects for slices 0 to 3 |
| pin_r5 | output | 1 | Slice-5 select (active low) or latched address bit 1 |
| pin_r6 | output | 1 | Slice-6 select (active low) or latched address bit 2 |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 256-byte slices and a 3-bit slice index, with index 4 left without a pin. With these values every index from 0 to 7 can be reached by a single strobe, so the missing slice and the index beyond the last slice are both exercised. The 9-bit base is small enough that random addresses biased toward the programmed base give frequent hits, near misses and space mismatches. The bench also writes the configuration while hold is active and while strobes are arriving.

// File: rtl/psel_pkg.sv
package psel_pkg;

  typedef enum logic {
    PIN_ADDR = 1'b0,
    PIN_SEL  = 1'b1
  } pin_mode_e;

  typedef struct packed {
    logic      io_space;
    pin_mode_e mode;
  } cfg_flags_t;

  localparam cfg_flags_t CFG_FLAGS_RST = '{io_space: 1'b0, mode: PIN_SEL};

  function automatic logic slice_has_pin(input int idx, input int missing);
    return idx != missing;
  endfunction

endpackage

// File: rtl/psel_cfg_reg.sv
module psel_cfg_reg
  import psel_pkg::*;
#(
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BASE_W-1:0] base_i,
  input  logic              io_i,
  input  logic              mode_i,
  output logic [BASE_W-1:0] base_q,
  output cfg_flags_t        flags_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      flags_q <= CFG_FLAGS_RST;
    end else if (we) begin
      base_q           <= base_i;
      flags_q.io_space <= io_i;
      flags_q.mode     <= pin_mode_e'(mode_i);
    end
  end

endmodule

// File: rtl/psel_region_decode.sv
module psel_region_decode
  import psel_pkg::*;
#(
  parameter int UP_W        = 12,
  parameter int IDX_W       = 3,
  parameter int NUM_REG     = 7,
  parameter int MISSING_IDX = 4,
  localparam int BASE_W     = UP_W - IDX_W
) (
  input  logic [UP_W-1:0]    addr_up,
  input  logic               cyc_io,
  input  logic [BASE_W-1:0]  base,
  input  logic               io_space,
  output logic [NUM_REG-1:0] hit_vec
);

  logic             blk_hit;
  logic [IDX_W-1:0] idx;

  assign idx     = addr_up[IDX_W-1:0];
  assign blk_hit = (addr_up[UP_W-1:IDX_W] == base) && (cyc_io == io_space);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_slice
    if (slice_has_pin(r, MISSING_IDX)) begin : g_pin
      assign hit_vec[r] = blk_hit && (idx == IDX_W'(r));
    end else begin : g_nopin
      assign hit_vec[r] = 1'b0;
    end
  end

endmodule

// File: rtl/psel_sel_track.sv
module psel_sel_track #(
  parameter int NUM_REG = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               hold,
  input  logic [NUM_REG-1:0] hit_vec,
  output logic [NUM_REG-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (hold)   sel_q <= '0;
    else if (strobe) sel_q <= hit_vec;
  end

endmodule

// File: rtl/psel_addr_latch.sv
module psel_addr_latch #(
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             hold,
  input  logic [LAT_W-1:0] bits_i,
  output logic [LAT_W-1:0] bits_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)                bits_q <= '0;
    else if (strobe && !hold)  bits_q <= bits_i;
  end

endmodule

// File: rtl/psel_decoder.sv
module psel_decoder
  import psel_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SLICE_BITS  = 8,
  parameter int IDX_W       = 3,
  parameter int NUM_REG     = 7,
  parameter int MISSING_IDX = 4,
  parameter int BASE_W      = ADDR_W - SLICE_BITS - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_io_space,
  input  logic              cfg_sel_mode,
  input  logic              bus_as,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_io,
  input  logic              bus_hold,
  output logic [3:0]        psel_n,
  output logic              pin_r5,
  output logic              pin_r6
);

  localparam int UP_W = ADDR_W - SLICE_BITS;

  logic [BASE_W-1:0]  base_q;
  cfg_flags_t         flags_q;
  logic               sel_mode_q;
  logic [NUM_REG-1:0] hit_vec;
  logic [NUM_REG-1:0] sel_q;
  logic [1:0]         lat_q;
  logic               addr_unused;
  logic               sel_unused;

  assign sel_mode_q = (flags_q.mode == PIN_SEL);

  psel_cfg_reg #(.BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .base_i(cfg_base), .io_i(cfg_io_space), .mode_i(cfg_sel_mode),
    .base_q(base_q), .flags_q(flags_q)
  );

  psel_region_decode #(
    .UP_W(UP_W), .IDX_W(IDX_W), .NUM_REG(NUM_REG), .MISSING_IDX(MISSING_IDX)
  ) u_dec (
    .addr_up(bus_addr[ADDR_W-1:SLICE_BITS]), .cyc_io(bus_io),
    .base(base_q), .io_space(flags_q.io_space), .hit_vec(hit_vec)
  );

  psel_sel_track #(.NUM_REG(NUM_REG)) u_trk (
    .clk(clk), .rst_n(rst_n), .strobe(bus_as), .hold(bus_hold),
    .hit_vec(hit_vec), .sel_q(sel_q)
  );

  psel_addr_latch #(.LAT_W(2)) u_lat (
    .clk(clk), .rst_n(rst_n), .strobe(bus_as), .hold(bus_hold),
    .bits_i(bus_addr[2:1]), .bits_q(lat_q)
  );

  assign psel_n = bus_hold ? 4'hF : ~sel_q[3:0];
  assign pin_r5 = sel_mode_q ? (bus_hold | ~sel_q[5]) : lat_q[0];
  assign pin_r6 = sel_mode_q ? (bus_hold | ~sel_q[6]) : lat_q[1];

  assign addr_unused = ^{bus_addr[SLICE_BITS-1:3], bus_addr[0]};
  assign sel_unused  = ^sel_q[NUM_REG-1:0];

endmodule

// File: rtl/psel_decoder_chk.sv
module psel_decoder_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_as,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_hold,
  input logic              cfg_we,
  input logic              mode_q,
  input logic [3:0]        psel_n,
  input logic              pin_r5,
  input logic              pin_r6
);

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psel_n, mode_q & ~pin_r5, mode_q & ~pin_r6}) <= 1); // R2

  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> (psel_n == 4'hF)); // R7

  AST_NO_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as && !bus_hold) |=> (bus_hold || $stable(psel_n))); // R6

  AST_SLICE4_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && !bus_hold && bus_addr[10:8] == 3'd4) |=> (psel_n == 4'hF)); // R4

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hold && !mode_q && !cfg_we) |=> ($stable(pin_r5) && $stable(pin_r6))); // R9

endmodule

bind psel_decoder psel_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_addr(bus_addr),
  .bus_hold(bus_hold), .cfg_we(cfg_we), .mode_q(sel_mode_q),
  .psel_n(psel_n), .pin_r5(pin_r5), .pin_r6(pin_r6)
);

// File: tb/psel_decoder_bench.sv
module psel_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_io_space, cfg_sel_mode;
  logic [8:0]  cfg_base;
  logic        bus_as, bus_io, bus_hold;
  logic [19:0] bus_addr;
  logic [3:0]  psel_n;
  logic        pin_r5, pin_r6;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [8:0] m_base;
  logic       m_io, m_mode;
  int         m_reg;
  logic [1:0] m_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  psel_decoder u_psel_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_io_space(cfg_io_space), .cfg_sel_mode(cfg_sel_mode),
    .bus_as(bus_as), .bus_addr(bus_addr), .bus_io(bus_io), .bus_hold(bus_hold),
    .psel_n(psel_n), .pin_r5(pin_r5), .pin_r6(pin_r6)
  );

  function automatic logic [5:0] exp_pins();
    logic [5:0] v;
    for (int i = 0; i < 4; i++) v[i] = !(m_reg == i && !bus_hold);
    v[4] = m_mode ? !(m_reg == 5 && !bus_hold) : m_lat[0];
    v[5] = m_mode ? !(m_reg == 6 && !bus_hold) : m_lat[1];
    return v;
  endfunction

  function automatic int decode_model();
    int idx;
    idx = int'(bus_addr[10:8]);
    if (bus_addr[19:11] != m_base || bus_io != m_io) return -1;
    if (idx == 4 || idx == 7) return -1;
    return idx;
  endfunction

  function automatic void model_edge();
    if (bus_hold) m_reg = -1;
    else if (bus_as) m_reg = decode_model();
    if (bus_as && !bus_hold) m_lat = bus_addr[2:1];
    if (cfg_we) begin
      m_base = cfg_base; m_io = cfg_io_space; m_mode = cfg_sel_mode;
    end
  endfunction

  task automatic compare(input string tag);
    logic [5:0] got, exp;
    got = {pin_r6, pin_r5, psel_n};
    exp = exp_pins();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pins=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic bus(input logic as, input logic [19:0] a, input logic io, input logic h);
    bus_as = as; bus_addr = a; bus_io = io; bus_hold = h;
  endtask

  task automatic write_cfg(input logic [8:0] b, input logic io, input logic md, input string tag);
    cfg_base = b; cfg_io_space = io; cfg_sel_mode = md; cfg_we = 1'b1;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  function automatic logic [19:0] mk(input logic [8:0] b, input int idx, input logic [7:0] lo);
    return {b, idx[2:0], lo};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_base = '0; cfg_io_space = 0; cfg_sel_mode = 1;
    bus(0, '0, 0, 0);
    m_base = '0; m_io = 0; m_mode = 1; m_reg = -1; m_lat = 2'b00;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    tick("R1");

    // configure: base 0x0A5, memory space, select mode
    write_cfg(9'h0A5, 1'b0, 1'b1, "R10");

    for (int i = 0; i < 8; i++) begin
      bus(1, mk(9'h0A5, i, 8'h3C), 0, 0);
      if (i < 4) tick("R2");
      else if (i == 4 || i == 7) tick("R4");
      else tick("R3");
      bus(0, mk(9'h0A5, 2, 8'h00), 0, 0);
      tick("R6");
      tick("R6");
    end

    // mismatches
    bus(1, mk(9'h0A5, 1, 8'h10), 0, 0); tick("R2");
    bus(1, mk(9'h0A4, 1, 8'h10), 0, 0); tick("R5");
    bus(1, mk(9'h0A5, 2, 8'h10), 1, 0); tick("R5");

    // hold behaviour
    bus(1, mk(9'h0A5, 2, 8'h00), 0, 0); tick("R2");
    bus(0, '0, 0, 1);                   tick("R7");
    bus(1, mk(9'h0A5, 1, 8'h00), 0, 1); tick("R7");
    bus(0, '0, 0, 0);                   tick("R7");
    bus(1, mk(9'h0A5, 6, 8'h00), 0, 0); tick("R3");
    bus(0, '0, 0, 1);                   tick("R7");
    bus(0, '0, 0, 0);

    // latched-address mode
    write_cfg(9'h0A5, 1'b0, 1'b0, "R10");
    bus(1, 20'h12342, 0, 0);            tick("R8");
    bus(0, 20'h00006, 0, 0);            tick("R8");
    bus(1, mk(9'h0A5, 5, 8'h04), 0, 0); tick("R8");
    bus(1, 20'h00006, 0, 1);            tick("R9");
    bus(1, 20'h00000, 0, 1);            tick("R9");
    write_cfg(9'h0A5, 1'b0, 1'b0, "R9");
    bus(0, '0, 0, 0);                   tick("R9");

    // I/O space, new base; write during strobe uses old config
    write_cfg(9'h013, 1'b1, 1'b1, "R10");
    bus(1, mk(9'h013, 3, 8'h00), 1, 0); tick("R10");
    bus(1, mk(9'h013, 0, 8'h00), 0, 0); tick("R5");
    cfg_base = 9'h100; cfg_io_space = 0; cfg_sel_mode = 1; cfg_we = 1;
    bus(1, mk(9'h100, 1, 8'h00), 0, 0); tick("R10");
    cfg_we = 0;
    bus(1, mk(9'h100, 1, 8'h00), 0, 0); tick("R10");

    // constrained random
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 4000; n++) begin
      logic [8:0] b;
      int r;
      r = $urandom_range(0, 99);
      b = (r < 70) ? m_base : 9'($urandom);
      bus(($urandom_range(0, 2) != 0), mk(b, $urandom_range(0, 7), 8'($urandom)),
          ($urandom_range(0, 9) == 0) ? ~m_io : m_io, ($urandom_range(0, 11) == 0));
      if ($urandom_range(0, 59) == 0) begin
        cfg_we = 1; cfg_base = ($urandom_range(0, 1) != 0) ? m_base : 9'($urandom);
        cfg_io_space = ($urandom_range(0, 4) == 0); cfg_sel_mode = ($urandom_range(0, 2) != 0);
      end
      tick("R6");
      cfg_we = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule